// File: doc/BRIEF.md
# Two-Wire Target with Persistent Register Pointer

This block is a two-wire serial bus target (I2C style) placed in front of a small bank of byte registers. A fast system clock oversamples the SCL and SDA lines. The block finds START, repeated START and STOP conditions and answers one fixed 7-bit device address. It acknowledges by pulling SDA low through an open-drain output enable. The block never drives SDA high.

A register pointer lives inside the block. In a write transfer, the first byte after the address loads the pointer. Every byte after that is written to the register the pointer selects. In a read transfer, bytes are returned starting at the pointer. The pointer advances by one after every byte moved in either direction. It wraps at the top of the bank and keeps its value across transfers, so a read that is not preceded by a pointer write carries on from where the previous transfer stopped.

The register bank is outside the block. It is reached through a one-cycle write strobe and an asynchronous read port, whose data must be valid in the same cycle as the read address.

Top module: `i2c_ptr_target`

## Requirements
- R1: A START followed by address byte 0b1101000 plus a direction bit (bit 0 of the byte: 0 = write, 1 = read) is acknowledged: SDA is pulled low during the ninth clock.
- R2: Any other address is not acknowledged. SDA stays released and no register is written until the next START or STOP.
- R3: In a write transfer, the first byte after the address loads its low 4 bits into the pointer and is acknowledged. The upper 4 bits are ignored.
- R4: Every later byte in a write transfer is written to the register at the pointer and acknowledged, and the pointer then advances by one.
- R5: The 4-bit pointer wraps from 15 to 0, and it is visible on the read-address port.
- R6: In a read transfer, bytes are sent MSB first, starting with the register at the pointer, and the pointer advances by one per byte.
- R7: A read with no pointer write before it starts at the stored pointer value left by the previous transfer, including a transfer that ended with STOP.
- R8: A read goes on while the master acknowledges. After a master not-acknowledge, the block releases SDA and sends nothing more.
- R9: A repeated START ends the current transfer and begins a new address phase, in either direction, without a STOP.
- R10: The SDA output enable changes only while SCL is low, and it is the only way the block affects SDA.
- R11: After reset, SDA is released, no write strobe is active and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_waddr | output | 4 | Register write address |
| reg_wdata | output | 8 | Register write data |
| reg_raddr | output | 4 | Register read address (the current pointer) |
| reg_rdata | input | 8 | Register read data, valid in the same cycle as reg_raddr |

## Verification
The hardest case to reach is the pointer carrying over from one transfer to the next. It only shows up when a read is started with no pointer write in front of it, after an earlier transfer has moved the pointer by a known amount, sometimes across the wrap point. The stimulus chains transfers on purpose. A full 16-byte fill leaves the pointer wrapped back to 0. A write starting at 14 crosses the top. Every address and direction pair is swept, and matching reads in that sweep keep advancing the pointer. Each later read is then checked against a pointer value the bench works out arithmetically.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK_TX,
    S_TX,
    S_ACK_RX
  } tgt_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } rx_phase_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);

  logic [STAGES-1:0] scl_ff_q, scl_ff_d;
  logic [STAGES-1:0] sda_ff_q, sda_ff_d;
  logic              scl_d_q, sda_d_q;

  generate
    if (STAGES == 1) begin : g_single
      always_comb begin
        scl_ff_d = scl_i;
        sda_ff_d = sda_i;
      end
    end else begin : g_chain
      always_comb begin
        scl_ff_d = {scl_ff_q[STAGES-2:0], scl_i};
        sda_ff_d = {sda_ff_q[STAGES-2:0], sda_i};
      end
    end
  endgenerate

  // idle bus reads high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff_q <= '1;
      sda_ff_q <= '1;
      scl_d_q  <= 1'b1;
      sda_d_q  <= 1'b1;
    end else begin
      scl_ff_q <= scl_ff_d;
      sda_ff_q <= sda_ff_d;
      scl_d_q  <= scl_ff_q[STAGES-1];
      sda_d_q  <= sda_ff_q[STAGES-1];
    end
  end

  assign scl_s     = scl_ff_q[STAGES-1];
  assign sda_s     = sda_ff_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d_q;
  assign scl_fall  = ~scl_s & scl_d_q;
  assign start_det = scl_s & scl_d_q & sda_d_q & ~sda_s;
  assign stop_det  = scl_s & scl_d_q & ~sda_d_q & sda_s;

endmodule

// File: rtl/i2c_reg_ptr.sv
module i2c_reg_ptr #(
  parameter int unsigned PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [PTR_W-1:0] ld_val,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);

  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (ld) begin
      ptr_d = ld_val;
    end else if (inc) begin
      ptr_d = ptr_q + 1'b1;   // natural wrap at 2**PTR_W
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ld || inc) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/i2c_ptr_fsm.sv
module i2c_ptr_fsm
  import i2c_ptr_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h68,
  parameter int unsigned PTR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic [PTR_W-1:0]  ptr,
  output logic              ptr_ld,
  output logic [PTR_W-1:0]  ptr_ld_val,
  output logic              ptr_inc,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [PTR_W-1:0]  reg_waddr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata
);

  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(BYTE_W);

  tgt_state_e        state_q, state_d;
  rx_phase_e         phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;
  logic              oe_q, oe_d;
  logic              we_q, we_d;
  logic [PTR_W-1:0]  waddr_q, waddr_d;
  logic [BYTE_W-1:0] wdata_q, wdata_d;

  always_comb begin
    state_d    = state_q;
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    rw_d       = rw_q;
    mack_d     = mack_q;
    oe_d       = oe_q;
    we_d       = 1'b0;
    waddr_d    = waddr_q;
    wdata_d    = wdata_q;
    ptr_ld     = 1'b0;
    ptr_inc    = 1'b0;
    ptr_ld_val = sh_q[PTR_W-1:0];

    if (stop_det) begin
      state_d = S_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = S_RX;
      phase_d = PH_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: ;
        S_RX: begin
          if (scl_rise && (cnt_q < BITS_FULL)) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && (cnt_q == BITS_FULL)) begin
            unique case (phase_q)
              PH_ADDR: begin
                if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
                  rw_d    = sh_q[0];
                  oe_d    = 1'b1;
                  state_d = S_ACK_TX;
                end else begin
                  state_d = S_IDLE;
                end
              end
              PH_PTR: begin
                ptr_ld  = 1'b1;
                oe_d    = 1'b1;
                state_d = S_ACK_TX;
              end
              default: begin
                we_d    = 1'b1;
                waddr_d = ptr;
                wdata_d = sh_q;
                ptr_inc = 1'b1;
                oe_d    = 1'b1;
                state_d = S_ACK_TX;
              end
            endcase
          end
        end
        S_ACK_TX: begin
          if (scl_fall) begin
            cnt_d = '0;
            if ((phase_q == PH_ADDR) && rw_q) begin
              sh_d    = reg_rdata;
              oe_d    = ~reg_rdata[BYTE_W-1];
              ptr_inc = 1'b1;
              state_d = S_TX;
            end else begin
              oe_d    = 1'b0;
              state_d = S_RX;
              phase_d = (phase_q == PH_ADDR) ? PH_PTR : PH_DATA;
            end
          end
        end
        S_TX: begin
          if (scl_rise && (cnt_q < BITS_FULL)) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == BITS_FULL) begin
              oe_d    = 1'b0;
              mack_d  = 1'b0;
              cnt_d   = '0;
              state_d = S_ACK_RX;
            end else if (cnt_q != '0) begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        S_ACK_RX: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              sh_d    = reg_rdata;
              oe_d    = ~reg_rdata[BYTE_W-1];
              ptr_inc = 1'b1;
              cnt_d   = '0;
              state_d = S_TX;
            end else begin
              state_d = S_IDLE;
            end
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      phase_q <= PH_ADDR;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
    end
  end

  assign sda_oe    = oe_q;
  assign reg_we    = we_q;
  assign reg_waddr = waddr_q;
  assign reg_wdata = wdata_q;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |-> !sda_oe);  // R2
  AST_ACK_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ACK_TX) |-> sda_oe);  // R1
  AST_WE_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past((state_q == S_RX) && (phase_q == PH_DATA)));  // R4
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (ptr == PTR_W'(reg_waddr + 1'b1)));  // R5
  AST_BIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= BITS_FULL);  // R6

endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
  import i2c_ptr_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h68,
  parameter int unsigned PTR_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [PTR_W-1:0]  reg_waddr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic [PTR_W-1:0]  reg_raddr,
  input  logic [BYTE_W-1:0] reg_rdata
);

  logic [1:0]       rst_ff_q;
  logic             rst_int_n;
  logic             scl_s, sda_s, start_det, stop_det, scl_rise, scl_fall;
  logic             ptr_ld, ptr_inc;
  logic [PTR_W-1:0] ptr_ld_val, ptr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_ff_q <= 2'b00;
    end else begin
      rst_ff_q <= {rst_ff_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_ff_q[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall)
  );

  i2c_reg_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .ld     (ptr_ld),
    .ld_val (ptr_ld_val),
    .inc    (ptr_inc),
    .ptr    (ptr)
  );

  i2c_ptr_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sda_s      (sda_s),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .ptr        (ptr),
    .ptr_ld     (ptr_ld),
    .ptr_ld_val (ptr_ld_val),
    .ptr_inc    (ptr_inc),
    .sda_oe     (sda_oe),
    .reg_we     (reg_we),
    .reg_waddr  (reg_waddr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata)
  );

  assign reg_raddr = ptr;

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(sda_oe) |-> !scl_s);  // R10
  AST_NO_WE_IN_RESET: assert property (@(posedge clk)
    !rst_int_n |-> !reg_we);  // R11

endmodule

// File: tb/test_i2c_ptr_target.sv
module test_i2c_ptr_target;

  localparam int NREG = 16;
  localparam logic [6:0] DEV = 7'h68;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_bus;
  logic       sda_oe, reg_we;
  logic [3:0] reg_waddr, reg_raddr;
  logic [7:0] reg_wdata, reg_rdata;

  logic [7:0] bank [NREG];
  logic [7:0] exp_bank [NREG];
  int         exp_ptr = 0;
  int         checks = 0;
  int         fails = 0;
  int         oe_viol = 0;
  logic       oe_prev = 1'b0;
  bit         done = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_ptr_target i_i2c_ptr_target (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_bus),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .reg_wdata (reg_wdata),
    .reg_raddr (reg_raddr),
    .reg_rdata (reg_rdata)
  );

  always @(posedge clk) if (reg_we) bank[reg_waddr] <= reg_wdata;
  assign reg_rdata = bank[reg_raddr];

  // R10 monitor: enable may only move while SCL is low
  always @(posedge clk) begin
    #1;
    if (rst_n && (sda_oe !== oe_prev) && scl_m) oe_viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(4);
    scl_m = 1'b1; wt(8);
    sda_m = 1'b0; wt(8);
    scl_m = 1'b0; wt(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(4);
    scl_m = 1'b1; wt(8);
    sda_m = 1'b1; wt(8);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b;    wt(4);
    scl_m = 1'b1; wt(4);
    s = sda_bus;  wt(4);
    scl_m = 1'b0; wt(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = (s == 1'b0);
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clk_bit(mack ? 1'b0 : 1'b1, s);
  endtask

  task automatic cmp_bank(input string req);
    for (int i = 0; i < NREG; i++) chk(req, $sformatf("bank[%0d]", i), bank[i], exp_bank[i]);
  endtask

  task automatic write_regs(input logic [7:0] p, input int n, input logic [7:0] seed);
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b0}, a);  chk("R1", "write address ack", a, 1);
    send_byte(p, a);            chk("R3", "pointer byte ack", a, 1);
    exp_ptr = p % NREG;
    for (int k = 0; k < n; k++) begin
      d = seed ^ 8'(k * 37);
      send_byte(d, a);          chk("R4", "data byte ack", a, 1);
      exp_bank[exp_ptr] = d;
      exp_ptr = (exp_ptr + 1) % NREG;
    end
    bus_stop();
    chk("R5", "pointer after write", reg_raddr, exp_ptr);
  endtask

  task automatic read_regs(input int n);
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b1}, a);  chk("R1", "read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      read_byte(k != n - 1, d);
      chk("R6", $sformatf("read data at %0d", exp_ptr), d, exp_bank[exp_ptr]);
      exp_ptr = (exp_ptr + 1) % NREG;
    end
    wt(2);
    chk("R8", "SDA released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      report();
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] d;
    wt(5);
    chk("R11", "sda_oe in reset", sda_oe, 0);
    chk("R11", "reg_we in reset", reg_we, 0);
    chk("R11", "pointer in reset", reg_raddr, 0);
    rst_n = 1'b1;
    wt(6);
    chk("R11", "pointer after reset", reg_raddr, 0);

    // R4/R5: fill all registers, pointer wraps back to 0
    write_regs(8'h00, NREG, 8'h3C);
    cmp_bank("R4");
    // R7: read with no pointer write resumes at wrapped pointer 0
    read_regs(NREG);

    // R3/R5: upper pointer bits ignored, write crosses 15 -> 0
    write_regs(8'hFE, 4, 8'hA7);
    cmp_bank("R5");
    // R7: continue from stored pointer 2
    read_regs(3);

    // R6: read starting from every pointer value
    for (int p = 0; p < NREG; p++) begin
      write_regs(8'(p), 0, 8'h00);
      read_regs(2);
    end

    // R9: repeated START from write into read
    bus_start();
    send_byte({DEV, 1'b0}, a);  chk("R9", "addr ack", a, 1);
    send_byte(8'h09, a);        chk("R9", "ptr ack", a, 1);
    exp_ptr = 9;
    bus_start();
    send_byte({DEV, 1'b1}, a);  chk("R9", "read addr ack after rstart", a, 1);
    read_byte(1'b0, d);         chk("R9", "read after rstart", d, exp_bank[9]);
    exp_ptr = 10;
    // R9: repeated START from read into write
    bus_start();
    send_byte({DEV, 1'b0}, a);  chk("R9", "write addr ack after rstart", a, 1);
    send_byte(8'h01, a);        chk("R9", "ptr ack after rstart", a, 1);
    send_byte(8'h5A, a);        chk("R9", "data ack after rstart", a, 1);
    exp_bank[1] = 8'h5A;
    exp_ptr = 2;
    bus_stop();
    chk("R9", "bank[1] after rstart write", bank[1], 8'h5A);
    chk("R9", "pointer after rstart write", reg_raddr, exp_ptr);

    // R1/R2: sweep every address and direction
    for (int ad = 0; ad < 128; ad++) begin
      for (int rw = 0; rw < 2; rw++) begin
        bus_start();
        send_byte({7'(ad), 1'(rw)}, a);
        if (7'(ad) == DEV) begin
          chk("R1", $sformatf("ack addr %0h rw %0d", ad, rw), a, 1);
          if (rw == 0) begin
            send_byte(8'h07, a);  chk("R3", "sweep pointer ack", a, 1);
            exp_ptr = 7;
          end else begin
            read_byte(1'b0, d);
            chk("R7", "sweep read at stored pointer", d, exp_bank[exp_ptr]);
            exp_ptr = (exp_ptr + 1) % NREG;
          end
        end else begin
          chk("R2", $sformatf("no ack addr %0h rw %0d", ad, rw), a, 0);
          send_byte(8'h00, a);
          chk("R2", "no ack for byte after mismatch", a, 0);
        end
        bus_stop();
      end
    end
    cmp_bank("R2");
    chk("R7", "pointer after sweep", reg_raddr, exp_ptr);

    chk("R10", "enable changes while SCL high", oe_viol, 0);

    done = 1'b1;
    report();
    $finish;
  end

endmodule